// File: doc/BRIEF.md
# ATA PIO Cycle Timer

This block times programmed-I/O read and write cycles on a two-drive ATA channel. A cycle is split into three phases, each counted in bus clocks. First comes address setup. Next is the active data pulse, during which exactly one strobe (read or write) is asserted. The last phase is recovery. A host requests a cycle with a one-clock pulse on `req`, which carries a direction and a drive select. The block raises `busy` for the whole cycle and pulses `done` once when it ends.

The timing comes from a small register file. Each drive has its own bank, and a bank holds one timing byte for read cycles and one for write cycles. In each byte the high nibble is the active count minus one and the low nibble is the recovery count minus two. A configuration byte is shared by both drives. It holds the setup count, the ready-sample delay (brought out as `sample_dly` for the external ready sampler), and the bank pointer that steers later timing writes. A cycle latches its counts when it is accepted, so a write made mid-cycle only shapes later cycles.

Top module: `ata_pio_timer`

## Requirements
- R1: After reset `busy`, `rd_stb`, `wr_stb` and `done` are low and `sample_dly` is 2. Both banks hold the minimum timing: setup 1, active 1, recovery 2.
- R2: The setup phase lasts config bits [5:4] plus 1 clocks (1 to 4). During it `busy` is high and both strobes are low.
- R3: The active phase lasts timing bits [7:4] plus 1 clocks (1 to 16). `rd_stb` is asserted alone on a read (`req_wr`=0) and `wr_stb` alone on a write (`req_wr`=1). The two strobes are never high together, and no strobe is high outside this phase.
- R4: The recovery phase lasts timing bits [3:0] plus 2 clocks (2 to 17), with both strobes low.
- R5: `cfg_sel` picks the register written: 0 is the read timing byte, 1 is the write timing byte, 2 is the configuration byte, and 3 writes nothing. Read cycles use only the read byte and write cycles use only the write byte.
- R6: Cycles with `req_drv`=0 use bank A and cycles with `req_drv`=1 use bank B. Config bit 0 chooses the bank that receives timing writes (0 = A, 1 = B).
- R7: A single setup count, from the config byte, applies to cycles on both drives.
- R8: `sample_dly` equals config bits [2:1] plus 2.
- R9: A request is taken only while `busy` is low. A request made during a cycle is dropped and does not start a cycle later.
- R10: `busy` is high for setup+active+recovery clocks, starting the clock after the request is sampled. `done` is high for exactly the one clock after the last recovery clock.
- R11: A register write made while a cycle runs leaves that cycle's phase lengths unchanged and applies from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Cycle request, sampled on each rising edge |
| req_wr | input | 1 | Cycle direction: 1 for write, 0 for read |
| req_drv | input | 1 | Drive select for the requested cycle |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select: 0 read byte, 1 write byte, 2 config, 3 none |
| cfg_data | input | 8 | Register write data |
| rd_stb | output | 1 | Read strobe, high during the active phase of a read |
| wr_stb | output | 1 | Write strobe, high during the active phase of a write |
| busy | output | 1 | High from the first setup clock through the last recovery clock |
| done | output | 1 | One-clock pulse after recovery ends |
| sample_dly | output | 3 | Ready-sample delay in clocks |

## Verification
The bench aims at the extreme encodings: an all-ones active nibble (16 clocks), an all-ones recovery nibble (17 clocks), and the all-zero minimum. An offset that is off by one shows up there as a phase one clock short or long. It also runs a request into a busy cycle. A design that queued that request would start an extra cycle after `done`. It also rewrites the active bank in the middle of a cycle. A design that read the registers live instead of latching them would stretch or cut the running strobe. Finally, the bench alternates drives and directions after moving the bank pointer, which catches a mux that swaps banks or reads the wrong byte.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int NUM_SETS = 2;
  localparam int SET_W    = $clog2(NUM_SETS);
  localparam int CNT_W    = 5;
  localparam int DLY_W    = 3;
  localparam int BYTE_W   = 8;

  localparam logic [1:0] SEL_RD   = 2'd0;
  localparam logic [1:0] SEL_WR   = 2'd1;
  localparam logic [1:0] SEL_MISC = 2'd2;

  localparam logic [BYTE_W-1:0] RST_TIMING = '0;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  function automatic logic [CNT_W-1:0] setup_clks(input logic [1:0] f);
    return CNT_W'(f) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] act_clks(input logic [3:0] n);
    return CNT_W'(n) + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] rec_clks(input logic [3:0] n);
    return CNT_W'(n) + CNT_W'(2);
  endfunction

  function automatic logic [DLY_W-1:0] rdy_clks(input logic [1:0] f);
    return DLY_W'(f) + DLY_W'(2);
  endfunction
endpackage

// File: rtl/ata_pio_regs.sv
module ata_pio_regs
  import ata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [BYTE_W-1:0] cfg_data,
  input  logic [SET_W-1:0]  look_set,
  input  logic              look_wr,
  output logic [BYTE_W-1:0] timing_byte,
  output logic [1:0]        setup_f,
  output logic [1:0]        rdy_f
);
  logic [BYTE_W-1:0] rd_t [NUM_SETS];
  logic [BYTE_W-1:0] wr_t [NUM_SETS];
  logic [SET_W-1:0]  bank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_f <= '0;
      rdy_f   <= '0;
      bank    <= '0;
    end else if (cfg_we && cfg_sel == SEL_MISC) begin
      setup_f <= cfg_data[5:4];
      rdy_f   <= cfg_data[2:1];
      bank    <= cfg_data[SET_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
    logic hit;
    assign hit = cfg_we && (bank == SET_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rd_t[g] <= RST_TIMING;
        wr_t[g] <= RST_TIMING;
      end else begin
        if (hit && cfg_sel == SEL_RD) rd_t[g] <= cfg_data;
        if (hit && cfg_sel == SEL_WR) wr_t[g] <= cfg_data;
      end
    end
  end

  assign timing_byte = look_wr ? wr_t[look_set] : rd_t[look_set];
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] setup_n,
  input  logic [CNT_W-1:0] act_n,
  input  logic [CNT_W-1:0] rec_n,
  output phase_e           phase,
  output logic             cyc_wr,
  output logic             phase_last,
  output logic             done
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lat_act;
  logic [CNT_W-1:0] lat_rec;

  assign phase_last = (phase != PH_IDLE) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      lat_act <= '0;
      lat_rec <= '0;
      cyc_wr  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_SETUP;
          cnt     <= setup_n - CNT_W'(1);
          lat_act <= act_n;
          lat_rec <= rec_n;
          cyc_wr  <= start_wr;
        end
        PH_SETUP: if (cnt == '0) begin
          phase <= PH_ACTIVE;
          cnt   <= lat_act - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        PH_ACTIVE: if (cnt == '0) begin
          phase <= PH_RECOV;
          cnt   <= lat_rec - CNT_W'(1);
        end else cnt <= cnt - CNT_W'(1);
        PH_RECOV: if (cnt == '0) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end else cnt <= cnt - CNT_W'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
  import ata_pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_wr,
  input  logic             req_drv,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [7:0]       cfg_data,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             busy,
  output logic             done,
  output logic [2:0]       sample_dly
);
  logic [BYTE_W-1:0] timing_byte;
  logic [1:0]        setup_f;
  logic [1:0]        rdy_f;
  phase_e            phase;
  logic              cyc_wr;
  logic              phase_last;
  logic              accept;

  ata_pio_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_data    (cfg_data),
    .look_set    (SET_W'(req_drv)),
    .look_wr     (req_wr),
    .timing_byte (timing_byte),
    .setup_f     (setup_f),
    .rdy_f       (rdy_f)
  );

  assign accept = req && (phase == PH_IDLE);

  ata_pio_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_wr   (req_wr),
    .setup_n    (setup_clks(setup_f)),
    .act_n      (act_clks(timing_byte[7:4])),
    .rec_n      (rec_clks(timing_byte[3:0])),
    .phase      (phase),
    .cyc_wr     (cyc_wr),
    .phase_last (phase_last),
    .done       (done)
  );

  assign busy       = (phase != PH_IDLE);
  assign rd_stb     = (phase == PH_ACTIVE) && !cyc_wr;
  assign wr_stb     = (phase == PH_ACTIVE) &&  cyc_wr;
  assign sample_dly = rdy_clks(rdy_f);
endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_stb,
  input logic wr_stb,
  input logic busy,
  input logic done,
  input logic accept,
  input logic phase_last
);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  // R3
  strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> busy);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R9
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R10
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !phase_last) |=> busy);

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));
endmodule

bind ata_pio_timer ata_pio_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .busy       (busy),
  .done       (done),
  .accept     (accept),
  .phase_last (phase_last)
);

// File: tb/ata_pio_timer_test.sv
module ata_pio_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, req_wr = 1'b0, req_drv = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_data = 8'd0;
  logic       rd_stb, wr_stb, busy, done;
  logic [2:0] sample_dly;

  int n_tests = 0, n_fail = 0;

  logic [7:0] m_rd [2];
  logic [7:0] m_wr [2];
  int         m_setup, m_rdy, m_bank;

  ata_pio_timer uut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int e_setup();
    return m_setup + 1;
  endfunction
  function automatic int e_act(input bit drv, input bit wr);
    int b = wr ? int'(m_wr[drv]) : int'(m_rd[drv]);
    return (b / 16) + 1;
  endfunction
  function automatic int e_rec(input bit drv, input bit wr);
    int b = wr ? int'(m_wr[drv]) : int'(m_rd[drv]);
    return (b % 16) + 2;
  endfunction

  task automatic model_write(input logic [1:0] sel, input logic [7:0] d);
    case (sel)
      2'd0: m_rd[m_bank] = d;
      2'd1: m_wr[m_bank] = d;
      2'd2: begin m_setup = (d >> 4) & 3; m_rdy = (d >> 1) & 3; m_bank = d & 1; end
      default: ;
    endcase
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(sel, d);
  endtask

  task automatic run_cycle(input bit drv, input bit wr, input bit mid_cfg,
                           input bit stray, input logic [1:0] ms, input logic [7:0] md);
    int ea, ed, er, na, nd, nr, k;
    bit seen, bad;
    ea = e_setup(); ed = e_act(drv, wr); er = e_rec(drv, wr);
    na = 0; nd = 0; nr = 0; k = 0; seen = 0; bad = 0;
    @(negedge clk);
    req = 1'b1; req_drv = drv; req_wr = wr;
    while (k < 100) begin
      @(negedge clk);
      if (!busy) break;
      if (rd_stb || wr_stb) begin
        nd++; seen = 1;
        if (wr ? (!wr_stb || rd_stb) : (!rd_stb || wr_stb)) bad = 1;
      end else if (!seen) na++;
      else nr++;
      if (k == 0 && !stray) req = 1'b0;
      if (k == 0 && stray) req_drv = ~drv;
      if (k == 1) req = 1'b0;
      if (mid_cfg && k == 1) begin cfg_we = 1'b1; cfg_sel = ms; cfg_data = md; end
      if (mid_cfg && k == 2) begin cfg_we = 1'b0; model_write(ms, md); end
      k++;
    end
    chk(k < 100, "R10 cycle ended", k, 100);
    chk(na == ea, "R2 R7 setup clocks", na, ea);
    chk(nd == ed, "R3 R6 active clocks", nd, ed);
    chk(nr == er, "R4 R5 recovery clocks", nr, er);
    chk(!bad, "R3 strobe kind", bad, 0);
    chk(done == 1'b1, "R10 done after recovery", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single clock", done, 0);
    chk(busy == 1'b0, stray ? "R9 stray request dropped" : "R10 idle after done", busy, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    m_rd[0] = 0; m_rd[1] = 0; m_wr[0] = 0; m_wr[1] = 0;
    m_setup = 0; m_rdy = 0; m_bank = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rd_stb && !wr_stb && !done, "R1 outputs low", busy, 0);
    chk(sample_dly == 3'd2, "R1 sample delay", sample_dly, 2);
    run_cycle(0, 0, 0, 0, 0, 0);
    run_cycle(1, 1, 0, 0, 0, 0);

    // extremes on bank A, different read/write bytes (R5, R6)
    cfg_write(2'd2, 8'h00);
    cfg_write(2'd0, 8'hF0);
    cfg_write(2'd1, 8'h0F);
    cfg_write(2'd3, 8'hFF);          // R5: select 3 writes nothing
    cfg_write(2'd2, 8'h37);          // setup 4, ready 5, bank B
    chk(sample_dly == 3'd5, "R8 sample delay", sample_dly, 5);
    cfg_write(2'd0, 8'h52);
    cfg_write(2'd1, 8'hA9);
    run_cycle(0, 0, 0, 0, 0, 0);
    run_cycle(0, 1, 0, 0, 0, 0);
    run_cycle(1, 0, 0, 0, 0, 0);
    run_cycle(1, 1, 0, 0, 0, 0);
    cfg_write(2'd2, 8'h12);          // setup 2, ready 3, bank A
    chk(sample_dly == 3'd3, "R8 sample delay", sample_dly, 3);
    run_cycle(1, 0, 0, 0, 0, 0);     // R7 shared setup

    // R11 mid-cycle rewrite of the running byte
    run_cycle(0, 0, 1, 0, 2'd0, 8'h34);
    run_cycle(0, 0, 0, 0, 0, 0);
    // R11 mid-cycle change of setup
    run_cycle(1, 1, 1, 0, 2'd2, 8'h30);
    run_cycle(1, 1, 0, 0, 0, 0);
    // R9 request during a busy cycle
    run_cycle(0, 1, 0, 1, 0, 0);
    run_cycle(1, 0, 0, 1, 0, 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(0, 1) == 1)
        cfg_write(2'($urandom_range(0, 3)), 8'($urandom));
      if (i % 8 == 0) begin
        chk(int'(sample_dly) == m_rdy + 2, "R8 sample delay random", sample_dly, m_rdy + 2);
      end
      run_cycle(1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)), 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule